// File: doc/BRIEF.md
# Preemption Mask Gate

This block holds the three mask registers that decide whether a waiting exception may preempt the code that is running. One 1-bit lock raises the effective running level to 0. Another 1-bit lock raises it to -1. An 8-bit threshold masks everything at or below a chosen programmable level. Each cycle the block takes a candidate exception, given as a kind and an 8-bit priority value. It answers with a single allow/deny bit by comparing signed levels: the candidate's level must be strictly more urgent (numerically lower) than the current masking level.

The threshold has two write ports. The plain port loads any value. The raise-only port accepts a value only when that value tightens the mask. Only the upper `PRIO_BITS` bits of any priority value exist. Written data and candidate priorities are truncated to those bits before they are stored or compared. Writes are honoured only in privileged state. The -1 lock drops by itself on every exception exit except an exit from the non-maskable handler. Picking among several waiting exceptions is done elsewhere.

Top module: `prio_mask_gate`

## Requirements
- R1: After reset both locks and the threshold read as 0, and every candidate of every kind is allowed.
- R2: With `PRIO_BITS` = P, stored and compared priorities keep only bits [7:8-P] and the lower bits are zero. With P=3, writing 0xFF reads back 0xE0 and writing 0x1F reads back 0x00.
- R3: When the threshold is nonzero, a programmable candidate (kind 0 or 3) whose truncated priority is greater than or equal to the threshold is denied. A threshold of 0 masks nothing.
- R4: While the 0-lock is set, every programmable candidate is denied. A hard fault (kind 1, level -1) and an NMI (kind 2, level -2) are still allowed.
- R5: While the -1 lock is set, every candidate is denied except an NMI (kind 2).
- R6: A raise-only write is accepted only if its truncated value is nonzero and either the threshold is 0 or the value is strictly lower than the threshold. Otherwise the threshold is unchanged. If the plain and raise-only strobes come in the same cycle, the plain write wins.
- R7: An exception exit with `exit_nmi_i`=0 clears the -1 lock. An exit with `exit_nmi_i`=1 leaves it. A privileged write to the -1 lock in the same cycle takes precedence over the exit.
- R8: With `priv_i`=0, writes on every port are ignored and the mask registers keep their values.
- R9: A write takes effect on the clock edge at which its strobe is sampled. `allow_o` follows the registered masks and the current candidate inputs with no register delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| priv_i | input | 1 | 1 = privileged state, writes permitted |
| lock0_we_i | input | 1 | Write strobe for the level-0 lock |
| lock0_wd_i | input | 1 | Write data for the level-0 lock |
| lockm1_we_i | input | 1 | Write strobe for the level -1 lock |
| lockm1_wd_i | input | 1 | Write data for the level -1 lock |
| thr_we_i | input | 1 | Plain threshold write strobe |
| thr_raise_we_i | input | 1 | Raise-only threshold write strobe |
| thr_wd_i | input | 8 | Threshold write data |
| exc_exit_i | input | 1 | Exception exit event |
| exit_nmi_i | input | 1 | The exit is from the NMI handler |
| cand_kind_i | input | 2 | 0/3 programmable, 1 hard fault, 2 NMI |
| cand_prio_i | input | 8 | Candidate priority value |
| allow_o | output | 1 | 1 = candidate may preempt |
| lock0_o | output | 1 | Level-0 lock state |
| lockm1_o | output | 1 | Level -1 lock state |
| thr_o | output | 8 | Threshold state |

## Verification
On every cycle the assertions check the following. The -1 lock lets only an NMI through, and the 0-lock blocks every programmable kind. An NMI is never denied. A candidate at or beyond a nonzero threshold is denied. The stored threshold has no low bits set. A raise-only write never loosens a nonzero threshold. Unprivileged writes leave the registers alone. Exits clear or keep the -1 lock according to their kind.

Other properties need the bench's scenarios. One is the exact accepted/rejected outcome of the raise-only port, swept over every start level and every write value. Others are the exact allow map across all 256 priorities for each mask combination, the plain-over-raise collision, and the write-versus-exit precedence.

// File: rtl/pmask_pkg.sv
package pmask_pkg;
  localparam int PRIO_W = 8;
  localparam int LVL_W  = PRIO_W + 2;

  typedef enum logic [1:0] {
    KIND_IRQ  = 2'd0,
    KIND_HF   = 2'd1,
    KIND_NMI  = 2'd2,
    KIND_IRQ2 = 2'd3
  } cand_kind_e;

  typedef logic signed [LVL_W-1:0] level_t;

  localparam level_t LVL_OPEN = level_t'(1 << PRIO_W);
  localparam level_t LVL_HF   = -level_t'(1);
  localparam level_t LVL_NMI  = -level_t'(2);
endpackage

// File: rtl/pmask_trunc.sv
module pmask_trunc
  import pmask_pkg::*;
#(
  parameter int PRIO_BITS = 3
) (
  input  logic [PRIO_W-1:0] raw_i,
  output logic [PRIO_W-1:0] fmt_o
);
  if (PRIO_BITS >= PRIO_W) begin : g_full
    assign fmt_o = raw_i;
  end else begin : g_cut
    localparam logic [PRIO_W-1:0] KEEP = PRIO_W'((1 << PRIO_W) - (1 << (PRIO_W - PRIO_BITS)));
    assign fmt_o = raw_i & KEEP;
  end
endmodule

// File: rtl/pmask_regs.sv
module pmask_regs
  import pmask_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              priv_i,
  input  logic              lock0_we_i,
  input  logic              lock0_wd_i,
  input  logic              lockm1_we_i,
  input  logic              lockm1_wd_i,
  input  logic              thr_we_i,
  input  logic              thr_raise_we_i,
  input  logic [PRIO_W-1:0] thr_fmt_i,
  input  logic              exc_exit_i,
  input  logic              exit_nmi_i,
  output logic              lock0_q_o,
  output logic              lockm1_q_o,
  output logic [PRIO_W-1:0] thr_q_o
);
  logic              lock0_d, lockm1_d;
  logic [PRIO_W-1:0] thr_d;
  logic              raise_ok;

  // tighter means nonzero and more urgent than the current level
  assign raise_ok = (thr_fmt_i != '0) && ((thr_q_o == '0) || (thr_fmt_i < thr_q_o));

  always_comb begin
    lock0_d  = lock0_q_o;
    lockm1_d = lockm1_q_o;
    thr_d    = thr_q_o;
    if (priv_i && lock0_we_i) lock0_d = lock0_wd_i;
    if (priv_i && lockm1_we_i)          lockm1_d = lockm1_wd_i;
    else if (exc_exit_i && !exit_nmi_i) lockm1_d = 1'b0;
    if (priv_i && thr_we_i)                      thr_d = thr_fmt_i;
    else if (priv_i && thr_raise_we_i && raise_ok) thr_d = thr_fmt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lock0_q_o  <= 1'b0;
      lockm1_q_o <= 1'b0;
      thr_q_o    <= '0;
    end else begin
      lock0_q_o  <= lock0_d;
      lockm1_q_o <= lockm1_d;
      thr_q_o    <= thr_d;
    end
  end

  // R8
  unpriv_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !priv_i |=> ($stable(thr_q_o) && $stable(lock0_q_o)));

  // R8
  unpriv_lockm1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!priv_i && !exc_exit_i) |=> $stable(lockm1_q_o));

  // R6
  raise_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_i && thr_raise_we_i && !thr_we_i && thr_q_o != '0)
      |=> (thr_q_o != '0 && thr_q_o <= $past(thr_q_o)));

  // R7
  exit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_exit_i && !exit_nmi_i && !(priv_i && lockm1_we_i)) |=> !lockm1_q_o);

  // R7
  nmi_exit_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_exit_i && exit_nmi_i && !(priv_i && lockm1_we_i)) |=> $stable(lockm1_q_o));
endmodule

// File: rtl/pmask_decide.sv
module pmask_decide
  import pmask_pkg::*;
(
  input  logic              lock0_i,
  input  logic              lockm1_i,
  input  logic [PRIO_W-1:0] thr_i,
  input  logic [1:0]        kind_i,
  input  logic [PRIO_W-1:0] cand_fmt_i,
  output logic              allow_o
);
  level_t mask_lvl, cand_lvl;

  always_comb begin
    mask_lvl = LVL_OPEN;
    if (thr_i != '0) mask_lvl = level_t'({2'b00, thr_i});
    if (lock0_i)     mask_lvl = '0;
    if (lockm1_i)    mask_lvl = LVL_HF;
  end

  always_comb begin
    case (kind_i)
      KIND_HF:  cand_lvl = LVL_HF;
      KIND_NMI: cand_lvl = LVL_NMI;
      default:  cand_lvl = level_t'({2'b00, cand_fmt_i});
    endcase
  end

  assign allow_o = cand_lvl < mask_lvl;
endmodule

// File: rtl/prio_mask_gate.sv
module prio_mask_gate
  import pmask_pkg::*;
#(
  parameter int PRIO_BITS = 3
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       priv_i,
  input  logic       lock0_we_i,
  input  logic       lock0_wd_i,
  input  logic       lockm1_we_i,
  input  logic       lockm1_wd_i,
  input  logic       thr_we_i,
  input  logic       thr_raise_we_i,
  input  logic [7:0] thr_wd_i,
  input  logic       exc_exit_i,
  input  logic       exit_nmi_i,
  input  logic [1:0] cand_kind_i,
  input  logic [7:0] cand_prio_i,
  output logic       allow_o,
  output logic       lock0_o,
  output logic       lockm1_o,
  output logic [7:0] thr_o
);
  localparam logic [PRIO_W-1:0] KEEP_MASK =
    (PRIO_BITS >= PRIO_W) ? '1 : PRIO_W'((1 << PRIO_W) - (1 << (PRIO_W - PRIO_BITS)));

  logic [PRIO_W-1:0] thr_fmt, cand_fmt;

  pmask_trunc #(.PRIO_BITS(PRIO_BITS)) u_trunc_thr (.raw_i(thr_wd_i),    .fmt_o(thr_fmt));
  pmask_trunc #(.PRIO_BITS(PRIO_BITS)) u_trunc_cand(.raw_i(cand_prio_i), .fmt_o(cand_fmt));

  pmask_regs u_regs (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .priv_i         (priv_i),
    .lock0_we_i     (lock0_we_i),
    .lock0_wd_i     (lock0_wd_i),
    .lockm1_we_i    (lockm1_we_i),
    .lockm1_wd_i    (lockm1_wd_i),
    .thr_we_i       (thr_we_i),
    .thr_raise_we_i (thr_raise_we_i),
    .thr_fmt_i      (thr_fmt),
    .exc_exit_i     (exc_exit_i),
    .exit_nmi_i     (exit_nmi_i),
    .lock0_q_o      (lock0_o),
    .lockm1_q_o     (lockm1_o),
    .thr_q_o        (thr_o)
  );

  pmask_decide u_decide (
    .lock0_i    (lock0_o),
    .lockm1_i   (lockm1_o),
    .thr_i      (thr_o),
    .kind_i     (cand_kind_i),
    .cand_fmt_i (cand_fmt),
    .allow_o    (allow_o)
  );

  // R5
  lockm1_nmi_only_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lockm1_o && cand_kind_i != KIND_NMI) |-> !allow_o);

  // R4
  lock0_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock0_o && (cand_kind_i == KIND_IRQ || cand_kind_i == KIND_IRQ2)) |-> !allow_o);

  // R4
  nmi_pass_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cand_kind_i == KIND_NMI) |-> allow_o);

  // R3
  thr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_o != '0 && cand_kind_i != KIND_HF && cand_kind_i != KIND_NMI &&
     (cand_prio_i & KEEP_MASK) >= thr_o) |-> !allow_o);

  // R2
  thr_fmt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (thr_o & ~KEEP_MASK) == '0);
endmodule

// File: tb/prio_mask_gate_tb_top.sv
`timescale 1ns/1ps
module prio_mask_gate_tb_top;
  localparam int PB   = 3;
  localparam int KEEP = 256 - (1 << (8 - PB));

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       priv = 1'b0;
  logic       l0_we = 1'b0, l0_wd = 1'b0, lm_we = 1'b0, lm_wd = 1'b0;
  logic       t_we = 1'b0, t_rwe = 1'b0;
  logic [7:0] t_wd = '0;
  logic       ex = 1'b0, ex_nmi = 1'b0;
  logic [1:0] kind = '0;
  logic [7:0] prio = '0;
  logic       allow, l0, lm;
  logic [7:0] thr;

  int checks = 0, errors = 0;
  int m_l0 = 0, m_lm = 0, m_thr = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prio_mask_gate #(.PRIO_BITS(PB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .priv_i(priv),
    .lock0_we_i(l0_we), .lock0_wd_i(l0_wd),
    .lockm1_we_i(lm_we), .lockm1_wd_i(lm_wd),
    .thr_we_i(t_we), .thr_raise_we_i(t_rwe), .thr_wd_i(t_wd),
    .exc_exit_i(ex), .exit_nmi_i(ex_nmi),
    .cand_kind_i(kind), .cand_prio_i(prio),
    .allow_o(allow), .lock0_o(l0), .lockm1_o(lm), .thr_o(thr)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_allow(int k, int p);
    int cl, lvl;
    if (k == 1) cl = -1;
    else if (k == 2) cl = -2;
    else cl = p & KEEP;
    lvl = 256;
    if (m_thr != 0) lvl = m_thr;
    if (m_l0 != 0) lvl = 0;
    if (m_lm != 0) lvl = -1;
    return (cl < lvl) ? 1 : 0;
  endfunction

  // one clocked access; model follows the requirements
  task automatic acc(bit pv, bit a_we, bit a_wd, bit b_we, bit b_wd,
                     bit pw, bit rw, int d, bit e, bit en);
    int dm, n_l0, n_lm, n_thr;
    @(negedge clk);
    priv = pv; l0_we = a_we; l0_wd = a_wd; lm_we = b_we; lm_wd = b_wd;
    t_we = pw; t_rwe = rw; t_wd = 8'(d); ex = e; ex_nmi = en;
    dm = d & KEEP;
    n_l0 = m_l0; n_lm = m_lm; n_thr = m_thr;
    if (pv && a_we) n_l0 = a_wd;
    if (pv && b_we) n_lm = b_wd;
    else if (e && !en) n_lm = 0;
    if (pv && pw) n_thr = dm;
    else if (pv && rw && dm != 0 && (m_thr == 0 || dm < m_thr)) n_thr = dm;
    @(posedge clk);
    m_l0 = n_l0; m_lm = n_lm; m_thr = n_thr;
    @(negedge clk);
    l0_we = 0; lm_we = 0; t_we = 0; t_rwe = 0; ex = 0; ex_nmi = 0; priv = 0;
  endtask

  task automatic regs_chk(string req);
    #1;
    chk(req, int'(l0), m_l0);
    chk(req, int'(lm), m_lm);
    chk(req, int'(thr), m_thr);
  endtask

  task automatic sweep(string req);
    for (int k = 0; k < 4; k++) begin
      for (int p = 0; p < 256; p++) begin
        @(negedge clk);
        kind = 2'(k); prio = 8'(p);
        #1;
        chk(req, int'(allow), exp_allow(k, p));
      end
    end
  endtask

  task automatic plain(int d);
    acc(1, 0, 0, 0, 0, 1, 0, d, 0, 0);
  endtask

  task automatic raise(int d);
    acc(1, 0, 0, 0, 0, 0, 1, d, 0, 0);
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state, everything allowed
    regs_chk("R1");
    sweep("R1");

    // R2 truncation of written values
    plain(8'hFF); regs_chk("R2");
    chk("R2", int'(thr), 8'hE0);
    plain(8'h1F); regs_chk("R2");
    chk("R2", int'(thr), 0);
    for (int v = 0; v < 256; v++) begin
      plain(v);
      #1; chk("R2", int'(thr), v & KEEP);
    end

    // R3 threshold masking
    plain(8'h60); sweep("R3");
    plain(8'h20); sweep("R3");
    plain(8'hE0); sweep("R3");
    plain(0);     sweep("R3");

    // R6 raise-only port, worked sequence
    plain(8'h60); raise(8'hF0); regs_chk("R6");
    chk("R6", int'(thr), 8'h60);
    raise(8'h40); regs_chk("R6");
    chk("R6", int'(thr), 8'h40);
    raise(0);     regs_chk("R6");
    raise(8'h40); regs_chk("R6");
    raise(8'h1F); regs_chk("R6");
    // R6 plain wins over raise-only in the same cycle
    acc(1, 0, 0, 0, 0, 1, 1, 8'h80, 0, 0); regs_chk("R6");
    chk("R6", int'(thr), 8'h80);
    // R6 sweep: every start level against every write value
    for (int s = 0; s < 256; s += 32) begin
      for (int v = 0; v < 256; v += 4) begin
        plain(s);
        raise(v);
        #1; chk("R6", int'(thr), m_thr);
      end
    end
    plain(0);

    // R4 level-0 lock over a threshold
    plain(8'hA0);
    acc(1, 1, 1, 0, 0, 0, 0, 0, 0, 0); regs_chk("R4");
    sweep("R4");
    acc(1, 1, 0, 0, 0, 0, 0, 0, 0, 0); regs_chk("R4");
    sweep("R3");

    // R5 level -1 lock
    acc(1, 0, 0, 1, 1, 0, 0, 0, 0, 0); regs_chk("R5");
    sweep("R5");
    // R7 exits
    acc(0, 0, 0, 0, 0, 0, 0, 0, 1, 1); regs_chk("R7");
    chk("R7", int'(lm), 1);
    acc(0, 0, 0, 0, 0, 0, 0, 0, 1, 0); regs_chk("R7");
    chk("R7", int'(lm), 0);
    acc(1, 0, 0, 1, 1, 0, 0, 0, 1, 0); regs_chk("R7");
    chk("R7", int'(lm), 1);

    // R8 unprivileged writes ignored
    acc(1, 1, 1, 0, 0, 1, 0, 8'h40, 0, 0);
    acc(0, 1, 0, 1, 0, 1, 0, 8'hC0, 0, 0); regs_chk("R8");
    acc(0, 0, 0, 0, 0, 0, 1, 8'h20, 0, 0); regs_chk("R8");
    chk("R8", int'(thr), 8'h40);
    chk("R8", int'(l0), 1);
    chk("R8", int'(lm), 1);

    // R9 write seen by allow after one edge
    acc(1, 1, 0, 1, 0, 1, 0, 8'h80, 0, 0);
    @(negedge clk); kind = 2'd0; prio = 8'h60; #1;
    chk("R9", int'(allow), 1);
    acc(1, 0, 0, 0, 0, 1, 0, 8'h60, 0, 0);
    @(negedge clk); kind = 2'd0; prio = 8'h60; #1;
    chk("R9", int'(allow), 0);

    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule